// File: doc/BRIEF.md
# UART Receive Error Status and Interrupt Flags

This block holds the error and status state of a UART receiver, along with its interrupt requests. The deserialiser sits outside the block. It reports parity, framing and overrun faults as single-cycle pulses, and it presents each received byte with a valid strobe. A per-type detection enable in the control word decides whether each fault pulse is recorded as a sticky flag.

Software reads the flags and the receiver-enable bit from a read-only status word. Writing that word has no effect. The flags change only through a separate write-only strobe word, in which each bit written as 1 acts on one flag. Transmit, receive and error events are latched into a pending word that software clears by writing 1s. An enable word masks the pending bits onto the interrupt lines, and that enable word also gates a level interrupt for free transmit buffer space. Bytes that arrive while the receiver is disabled are dropped.

Register addresses (word index on `wr_addr`/`rd_addr`): 0 control, 1 status, 2 set/clear strobes, 3 interrupt enable, 4 interrupt pending. Writes take effect at the clock edge. Reads are combinational, and unmapped addresses read as 0.

Top module: `uerr_status`

## Requirements
- R1: After reset every register reads 0, the receiver is disabled, and all interrupt outputs and `rx_keep_o` are low.
- R2: An error pulse on the cycle after its detection enable is 1 sets the matching status flag at the next edge. The status flags sit at bit 16 (parity), bit 17 (framing) and bit 19 (overrun). The detection enables sit at control bit 18 (parity), bit 17 (framing) and bit 19 (overrun). A pulse whose enable is 0 leaves the flag unchanged. Flags stay set until cleared.
- R3: A write to the status address changes nothing.
- R4: Writing the strobe word clears the parity flag with bit 2, the framing flag with bit 3 and the overrun flag with bit 5. Any combination clears in one write, a 0 bit leaves its flag alone, and the strobe word reads as 0.
- R5: An enabled error pulse in the same cycle as its clear strobe leaves the flag set.
- R6: Receiver enable reads at status bit 0. Strobe bit 1 sets it and strobe bit 0 clears it. When both are written together the set wins.
- R7: A byte with `rx_valid_i` high while the receiver is disabled is discarded: `rx_keep_o` stays low and no receive interrupt is latched. While enabled, the byte appears on `rx_byte_o` with `rx_keep_o` high one cycle later.
- R8: Pending bit 0 latches `tx_done_i`, bit 1 latches an accepted byte, and bit 2 latches any enabled error pulse.
- R9: Writing 1 to a pending bit clears it, and a 0 leaves it. A new event in the same cycle as its clear leaves the bit set.
- R10: `irq_tx_o`, `irq_rx_o` and `irq_err_o` equal pending bits 0, 1 and 2 gated by enable bits 0, 1 and 2. `irq_txbuf_o` equals enable bit 3 gated by `txbuf_free_i`.
- R11: The control word reads back only bits 17, 18 and 19, and the enable word reads back only bits 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| err_par_i | input | 1 | Parity fault pulse |
| err_frm_i | input | 1 | Framing fault pulse |
| err_ovr_i | input | 1 | Overrun fault pulse |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | BYTE_W | Received byte |
| tx_done_i | input | 1 | Transmit event pulse |
| txbuf_free_i | input | 1 | Transmit buffer has room (level) |
| rx_keep_o | output | 1 | Accepted byte strobe |
| rx_byte_o | output | BYTE_W | Accepted byte |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_err_o | output | 1 | Error interrupt |
| irq_txbuf_o | output | 1 | Transmit buffer interrupt |

## Verification
The two actions that collide are a clear write and a new event on the same edge. One case is a flag strobe against an enabled error pulse. The other is a pending write-1 against a fresh transmit event. The bench drives both in the same low clock phase so that one edge samples them together. It then reads the status and pending words and expects the event to win, while the other bits selected by the same write are cleared. Separate sweeps cover every combination of enables and pulses, and every strobe pattern.

// File: rtl/uerr_pkg.sv
package uerr_pkg;
   localparam int NERR = 3;
   localparam int E_PAR = 0;
   localparam int E_FRM = 1;
   localparam int E_OVR = 2;

   localparam int A_CTRL = 0;
   localparam int A_STAT = 1;
   localparam int A_SCLR = 2;
   localparam int A_IEN  = 3;
   localparam int A_PEND = 4;

   localparam int STAT_REN   = 0;
   localparam int SCLR_RCLR  = 0;
   localparam int SCLR_RSET  = 1;
   localparam int NIRQ       = 3;
   localparam int IEN_W      = 4;
   localparam int IEN_TXBUF  = 3;
   localparam int MIN_DATA_W = 20;

   // status bit of each error type
   function automatic int stat_pos(input int t);
      case (t)
         E_PAR:   return 16;
         E_FRM:   return 17;
         default: return 19;
      endcase
   endfunction

   // control bit enabling detection of each error type
   function automatic int ctrl_pos(input int t);
      case (t)
         E_PAR:   return 18;
         E_FRM:   return 17;
         default: return 19;
      endcase
   endfunction

   // strobe bit clearing each error type
   function automatic int clr_pos(input int t);
      case (t)
         E_PAR:   return 2;
         E_FRM:   return 3;
         default: return 5;
      endcase
   endfunction
endpackage

// File: rtl/uerr_cfg_regs.sv
module uerr_cfg_regs
   import uerr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_ien,
   input  logic [DATA_W-1:0] wdata,
   output logic [NERR-1:0]   det_en,
   output logic [IEN_W-1:0]  ien
);
   logic [NERR-1:0]  det_q;
   logic [IEN_W-1:0] ien_q;

   for (genvar i = 0; i < NERR; i++) begin : g_det
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       det_q[i] <= 1'b0;
         else if (wr_ctrl) det_q[i] <= wdata[ctrl_pos(i)];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien_q <= '0;
      else if (wr_ien) ien_q <= wdata[IEN_W-1:0];
   end

   assign det_en = det_q;
   assign ien    = ien_q;
endmodule

// File: rtl/uerr_flags.sv
module uerr_flags
   import uerr_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NERR-1:0] ev,
   input  logic [NERR-1:0] det_en,
   input  logic [NERR-1:0] clr,
   input  logic            ren_set,
   input  logic            ren_clr,
   output logic [NERR-1:0] flag,
   output logic            ren,
   output logic            err_hit
);
   logic [NERR-1:0] hit;
   logic [NERR-1:0] flag_q;
   logic            ren_q;
   logic            ren_d;

   assign hit     = ev & det_en;
   assign err_hit = |hit;

   for (genvar i = 0; i < NERR; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[i] <= 1'b0;
         else        flag_q[i] <= hit[i] | (flag_q[i] & ~clr[i]);
      end
   end

   if (SET_WINS) begin : g_set_wins
      assign ren_d = ren_set | (ren_q & ~ren_clr);
   end else begin : g_clr_wins
      assign ren_d = ~ren_clr & (ren_set | ren_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ren_q <= 1'b0;
      else        ren_q <= ren_d;
   end

   assign flag = flag_q;
   assign ren  = ren_q;
endmodule

// File: rtl/uerr_irq.sv
module uerr_irq #(
   parameter int NSRC = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set,
   input  logic [NSRC-1:0] w1c,
   input  logic [NSRC-1:0] ien,
   output logic [NSRC-1:0] pend,
   output logic [NSRC-1:0] irq
);
   logic [NSRC-1:0] pend_q;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q[i] <= 1'b0;
         else        pend_q[i] <= set[i] | (pend_q[i] & ~w1c[i]);
      end
   end

   assign pend = pend_q;
   assign irq  = pend_q & ien;
endmodule

// File: rtl/uerr_status.sv
module uerr_status
   import uerr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 3,
   parameter int BYTE_W   = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              err_par_i,
   input  logic              err_frm_i,
   input  logic              err_ovr_i,
   input  logic              rx_valid_i,
   input  logic [BYTE_W-1:0] rx_byte_i,
   input  logic              tx_done_i,
   input  logic              txbuf_free_i,
   output logic              rx_keep_o,
   output logic [BYTE_W-1:0] rx_byte_o,
   output logic              irq_tx_o,
   output logic              irq_rx_o,
   output logic              irq_err_o,
   output logic              irq_txbuf_o
);
   localparam int NREG = A_PEND + 1;

   if (DATA_W < MIN_DATA_W) begin : g_bad_data_w
      $error("uerr_status: DATA_W too small for status fields");
   end
   if ((1 << ADDR_W) < NREG) begin : g_bad_addr_w
      $error("uerr_status: ADDR_W cannot reach all registers");
   end
   if (BYTE_W < 5 || BYTE_W > 9) begin : g_bad_byte_w
      $error("uerr_status: BYTE_W out of range");
   end

   logic            wr_ctrl, wr_ien, wr_sclr, wr_pend;
   logic [NERR-1:0] det_en;
   logic [IEN_W-1:0] ien;
   logic [NERR-1:0] ev;
   logic [NERR-1:0] clr;
   logic [NERR-1:0] flag;
   logic            ren;
   logic            err_hit;
   logic            rx_take;
   logic [NIRQ-1:0] pend;
   logic [NIRQ-1:0] irq;
   logic [NIRQ-1:0] pend_set;
   logic [NIRQ-1:0] pend_w1c;
   logic            keep_q;
   logic [BYTE_W-1:0] byte_q;

   assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
   assign wr_ien  = wr_en && (wr_addr == ADDR_W'(A_IEN));
   assign wr_sclr = wr_en && (wr_addr == ADDR_W'(A_SCLR));
   assign wr_pend = wr_en && (wr_addr == ADDR_W'(A_PEND));

   assign ev[E_PAR] = err_par_i;
   assign ev[E_FRM] = err_frm_i;
   assign ev[E_OVR] = err_ovr_i;

   for (genvar i = 0; i < NERR; i++) begin : g_clr
      assign clr[i] = wr_sclr & wr_data[clr_pos(i)];
   end

   uerr_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .wr_ien  (wr_ien),
      .wdata   (wr_data),
      .det_en  (det_en),
      .ien     (ien)
   );

   uerr_flags #(.SET_WINS(SET_WINS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev),
      .det_en  (det_en),
      .clr     (clr),
      .ren_set (wr_sclr & wr_data[SCLR_RSET]),
      .ren_clr (wr_sclr & wr_data[SCLR_RCLR]),
      .flag    (flag),
      .ren     (ren),
      .err_hit (err_hit)
   );

   assign rx_take  = rx_valid_i & ren;
   assign pend_set = {err_hit, rx_take, tx_done_i};
   assign pend_w1c = wr_pend ? wr_data[NIRQ-1:0] : '0;

   uerr_irq #(.NSRC(NIRQ)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (pend_set),
      .w1c   (pend_w1c),
      .ien   (ien[NIRQ-1:0]),
      .pend  (pend),
      .irq   (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep_q <= 1'b0;
         byte_q <= '0;
      end else begin
         keep_q <= rx_take;
         if (rx_take) byte_q <= rx_byte_i;
      end
   end

   assign rx_keep_o   = keep_q;
   assign rx_byte_o   = byte_q;
   assign irq_tx_o    = irq[0];
   assign irq_rx_o    = irq[1];
   assign irq_err_o   = irq[2];
   assign irq_txbuf_o = ien[IEN_TXBUF] & txbuf_free_i;

   always_comb begin
      rd_data = '0;
      case (int'(rd_addr))
         A_CTRL: begin
            for (int i = 0; i < NERR; i++) rd_data[ctrl_pos(i)] = det_en[i];
         end
         A_STAT: begin
            rd_data[STAT_REN] = ren;
            for (int i = 0; i < NERR; i++) rd_data[stat_pos(i)] = flag[i];
         end
         A_IEN:   rd_data[IEN_W-1:0] = ien;
         A_PEND:  rd_data[NIRQ-1:0]  = pend;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/uerr_chk.sv
module uerr_chk
   import uerr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              err_par_i,
   input logic              rx_valid_i,
   input logic              rx_keep_o,
   input logic [NERR-1:0]   det_en,
   input logic [NERR-1:0]   flag,
   input logic              ren,
   input logic [NIRQ-1:0]   pend
);
   logic sclr_wr, pend_wr;
   assign sclr_wr = wr_en && (wr_addr == ADDR_W'(A_SCLR));
   assign pend_wr = wr_en && (wr_addr == ADDR_W'(A_PEND));

   a_r2_par_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (err_par_i && det_en[E_PAR]) |=> flag[E_PAR]);

   a_r4_par_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (sclr_wr && wr_data[clr_pos(E_PAR)] && !(err_par_i && det_en[E_PAR]))
      |=> !flag[E_PAR]);

   a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[E_PAR] && !sclr_wr) |=> flag[E_PAR]);

   a_r7_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_i && !ren) |=> !rx_keep_o);

   a_r8_err_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flag ^ $past(flag)) && |flag) |-> pend[2]);

   a_r9_pend_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[0]) |-> $past(pend_wr && wr_data[0]));
endmodule

bind uerr_status uerr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .err_par_i  (err_par_i),
   .rx_valid_i (rx_valid_i),
   .rx_keep_o  (rx_keep_o),
   .det_en     (det_en),
   .flag       (flag),
   .ren        (ren),
   .pend       (pend)
);

// File: tb/uerr_status_test.sv
module uerr_status_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        err_par_i = 0, err_frm_i = 0, err_ovr_i = 0;
   logic        rx_valid_i = 0;
   logic [7:0]  rx_byte_i = '0;
   logic        tx_done_i = 0, txbuf_free_i = 0;
   logic        rx_keep_o;
   logic [7:0]  rx_byte_o;
   logic        irq_tx_o, irq_rx_o, irq_err_o, irq_txbuf_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   uerr_status uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .err_par_i(err_par_i), .err_frm_i(err_frm_i), .err_ovr_i(err_ovr_i),
      .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .tx_done_i(tx_done_i),
      .txbuf_free_i(txbuf_free_i), .rx_keep_o(rx_keep_o), .rx_byte_o(rx_byte_o),
      .irq_tx_o(irq_tx_o), .irq_rx_o(irq_rx_o), .irq_err_o(irq_err_o),
      .irq_txbuf_o(irq_txbuf_o)
   );

   localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, SCLR = 3'd2, IEN = 3'd3, PEND = 3'd4;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic ev(input logic [2:0] e);
      @(negedge clk);
      {err_ovr_i, err_frm_i, err_par_i} = e;
      @(negedge clk);
      {err_ovr_i, err_frm_i, err_par_i} = 3'b000;
   endtask

   // bench order: bit0 parity, bit1 framing, bit2 overrun
   function automatic logic [31:0] ctrl_of(input logic [2:0] en);
      return {12'd0, en[2], en[0], en[1], 17'd0};
   endfunction
   function automatic logic [31:0] stat_of(input logic [2:0] f, input logic r);
      return {12'd0, f[2], 1'b0, f[1], f[0], 15'd0, r};
   endfunction

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         finish_run();
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         chk("R1 reset read", d, 32'd0);
      end
      chk("R1 reset outputs", {28'd0, irq_tx_o, irq_rx_o, irq_err_o, rx_keep_o}, 32'd0);
      rst_n = 1'b1;

      // R11 read back of implemented bits
      wr(CTRL, 32'hFFFF_FFFF); rd(CTRL, d); chk("R11 ctrl readback", d, 32'h000E_0000);
      wr(IEN, 32'hFFFF_FFFF);  rd(IEN, d);  chk("R11 ien readback", d, 32'h0000_000F);
      wr(IEN, 32'd0);
      rd(SCLR, d); chk("R4 strobe reads zero", d, 32'd0);

      // R2 and R8: all detection enables against all pulse patterns
      for (int en = 0; en < 8; en++) begin
         for (int e = 0; e < 8; e++) begin
            logic [2:0] h;
            h = 3'(en) & 3'(e);
            wr(SCLR, 32'h2C);
            wr(PEND, 32'h7);
            wr(CTRL, ctrl_of(3'(en)));
            ev(3'(e));
            rd(STAT, d); chk("R2 flags after pulse", d, stat_of(h, 1'b0));
            rd(PEND, d); chk("R8 error pending", d, {29'd0, (h != 3'd0), 2'b00});
         end
      end

      // R4 and R6: every strobe pattern
      wr(CTRL, ctrl_of(3'b111));
      for (int m = 0; m < 64; m++) begin
         logic [5:0] mm;
         mm = 6'(m);
         wr(SCLR, 32'h1);
         ev(3'b111);
         wr(SCLR, {26'd0, mm});
         rd(STAT, d);
         chk("R4 R6 strobe pattern", d, stat_of({~mm[5], ~mm[3], ~mm[2]}, mm[1]));
      end

      // R6 clear alone
      wr(SCLR, 32'h2); wr(SCLR, 32'h1); rd(STAT, d);
      chk("R6 receiver cleared", d, 32'd0);

      // R3 status is read-only
      ev(3'b101);
      wr(STAT, 32'hFFFF_FFFF); rd(STAT, d);
      chk("R3 status write ignored", d, stat_of(3'b101, 1'b0));
      wr(STAT, 32'd0); rd(STAT, d);
      chk("R3 status write ignored", d, stat_of(3'b101, 1'b0));

      // R5 pulse in the same cycle as its clear
      for (int t = 0; t < 3; t++) begin
         ev(3'b111);
         @(negedge clk);
         wr_en = 1; wr_addr = SCLR; wr_data = 32'h2C;
         {err_ovr_i, err_frm_i, err_par_i} = 3'(1 << t);
         @(negedge clk);
         wr_en = 0; wr_data = '0; {err_ovr_i, err_frm_i, err_par_i} = 3'b000;
         rd(STAT, d); chk("R5 set beats clear", d, stat_of(3'(1 << t), 1'b0));
      end

      // R7 discard while disabled
      wr(SCLR, 32'h2C); wr(PEND, 32'h7); wr(SCLR, 32'h1);
      @(negedge clk); rx_valid_i = 1; rx_byte_i = 8'h5A;
      @(negedge clk); chk("R7 discard keep", {31'd0, rx_keep_o}, 32'd0);
      rx_valid_i = 0;
      rd(PEND, d); chk("R7 discard no rx pending", d, 32'd0);
      wr(SCLR, 32'h2);
      @(negedge clk); rx_valid_i = 1; rx_byte_i = 8'hC3;
      @(negedge clk); chk("R7 accept", {23'd0, rx_keep_o, rx_byte_o}, {23'd0, 1'b1, 8'hC3});
      rx_valid_i = 0;
      @(negedge clk); chk("R7 keep one cycle", {31'd0, rx_keep_o}, 32'd0);
      rd(PEND, d); chk("R8 rx pending", d, 32'h2);

      // R9 write-1-clear and same-cycle event
      @(negedge clk); tx_done_i = 1; @(negedge clk); tx_done_i = 0;
      ev(3'b001);
      rd(PEND, d); chk("R8 all pending", d, 32'h7);
      wr(PEND, 32'h2); rd(PEND, d); chk("R9 clear rx only", d, 32'h5);
      wr(PEND, 32'h0); rd(PEND, d); chk("R9 zero write", d, 32'h5);
      @(negedge clk);
      wr_en = 1; wr_addr = PEND; wr_data = 32'h5; tx_done_i = 1;
      @(negedge clk);
      wr_en = 0; wr_data = '0; tx_done_i = 0;
      rd(PEND, d); chk("R9 event beats clear", d, 32'h1);

      // R10 masking sweep
      @(negedge clk); tx_done_i = 1; rx_valid_i = 1; err_par_i = 1;
      @(negedge clk); tx_done_i = 0; rx_valid_i = 0; err_par_i = 0;
      for (int fr = 0; fr < 2; fr++) begin
         txbuf_free_i = fr[0];
         for (int m = 0; m < 16; m++) begin
            logic [3:0] mm;
            mm = 4'(m);
            wr(IEN, {28'd0, mm});
            #1;
            chk("R10 irq mask", {28'd0, irq_txbuf_o, irq_err_o, irq_rx_o, irq_tx_o},
                {28'd0, mm[3] & fr[0], mm[2:0]});
         end
      end

      done = 1;
      finish_run();
   end
endmodule